// File: doc/BRIEF.md
# Blanked Staggered Channel Enable

This block produces the final per-channel enable lines of a multi-channel output driver. Each channel has a request, which is its on/off bit with the global blank input low. A channel switches on only after a turn-on delay that grows with its index. Channel 0 switches on at once. Channel n waits n delay steps, and each step is a parameter counted in clock cycles. Spreading the turn-on events over time keeps all outputs from switching together, which limits the current surge on the supply.

Turn-off has no delay. Clearing a channel's bit, or raising blank, removes its enable in the same cycle. If a request is withdrawn while its delay is still running, the pending turn-on is dropped, and the next request starts the delay again from zero. The per-channel correction words pass through the block unchanged, so they stay aligned with the enables that use them.

Top module: `stagger_gate`

## Requirements
- R1: While `blank_i` is high, every bit of `en_o` is 0 in the same cycle, whatever `onoff_i` holds. After reset with blank high, `en_o` is all zeros.
- R2: While `blank_i` is low, a channel whose bit in `onoff_i` is 0 has its `en_o` bit at 0.
- R3: Channel 0 has no turn-on delay. `en_o[0]` rises in the same cycle as its request (blank low and `onoff_i[0]` high).
- R4: Channel n (bit n of `onoff_i` and `en_o`) turns on exactly n*STEP_CYC rising clock edges after its request first appears. It stays on while the request is held.
- R5: Clearing bit n of `onoff_i` clears `en_o[n]` in the same cycle.
- R6: Raising `blank_i` clears all enables in the same cycle. When blank falls again, the full staggered sequence of R4 starts over from zero.
- R7: If a request is withdrawn before its delay has expired, the pending turn-on is cancelled. A later request waits the full n*STEP_CYC edges again.
- R8: `corr_o` equals `corr_i` in the same cycle. Channel n's word occupies bits n*CORR_W +: CORR_W on both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blank_i | input | 1 | Global blank; high forces every enable off |
| onoff_i | input | NUM_CH | Per-channel on/off bits |
| corr_i | input | NUM_CH*CORR_W | Per-channel correction words |
| en_o | output | NUM_CH | Staggered channel enables |
| corr_o | output | NUM_CH*CORR_W | Correction words, passed through |

## Verification
The assertions assume that `blank_i` and `onoff_i` change only away from the rising clock edge. This means the request each lane counts is the same one seen at the ports. They also assume reset is released while the inputs are stable. The bench drives every input on the falling edge and samples one time unit later. Between requests it always lets at least one rising edge pass, so a withdrawn request is seen by the counters before it is re-raised.

// File: rtl/stagger_pkg.sv
package stagger_pkg;
   // width needed to hold values 0..maxv, never below one bit
   function automatic int cnt_width(input int maxv);
      int w;
      w = 1;
      while ((1 << w) <= maxv) w++;
      return w;
   endfunction
endpackage

// File: rtl/chan_req_gate.sv
module chan_req_gate #(
   parameter int NUM_CH = 16
) (
   input  logic              blank_i,
   input  logic [NUM_CH-1:0] onoff_i,
   output logic [NUM_CH-1:0] req_o
);
   always_comb begin
      req_o = blank_i ? '0 : onoff_i;
   end
endmodule

// File: rtl/stagger_lane.sv
module stagger_lane #(
   parameter int TARGET = 1,
   parameter int CW     = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic en_o
);
   localparam logic [CW-1:0] TGT = CW'(TARGET);

   generate
      if (TARGET < 1) begin : g_bad
         $error("stagger_lane: TARGET must be at least 1");
      end
   endgenerate

   logic [CW-1:0] wait_q;
   logic          done;

   assign done = (wait_q == TGT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       wait_q <= '0;
      else if (!req_i)  wait_q <= '0;
      else if (!done)   wait_q <= wait_q + 1'b1;
   end

   // off path is combinational so withdrawal is immediate
   assign en_o = req_i & done;
endmodule

// File: rtl/corr_pass.sv
module corr_pass #(
   parameter int NUM_CH = 16,
   parameter int CORR_W = 7
) (
   input  logic [NUM_CH*CORR_W-1:0] corr_i,
   output logic [NUM_CH*CORR_W-1:0] corr_o
);
   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_fld
         assign corr_o[n*CORR_W +: CORR_W] = corr_i[n*CORR_W +: CORR_W];
      end
   endgenerate
endmodule

// File: rtl/stagger_gate.sv
module stagger_gate #(
   parameter int NUM_CH   = 16,
   parameter int STEP_CYC = 1,
   parameter int CORR_W   = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     blank_i,
   input  logic [NUM_CH-1:0]        onoff_i,
   input  logic [NUM_CH*CORR_W-1:0] corr_i,
   output logic [NUM_CH-1:0]        en_o,
   output logic [NUM_CH*CORR_W-1:0] corr_o
);
   import stagger_pkg::*;

   localparam int MAX_WAIT = (NUM_CH - 1) * STEP_CYC;
   localparam int CW       = cnt_width(MAX_WAIT);

   generate
      if (NUM_CH < 1)   begin : g_e0 $error("NUM_CH must be >= 1");   end
      if (STEP_CYC < 1) begin : g_e1 $error("STEP_CYC must be >= 1"); end
      if (CORR_W < 1)   begin : g_e2 $error("CORR_W must be >= 1");   end
   endgenerate

   logic [NUM_CH-1:0] req;

   chan_req_gate #(.NUM_CH(NUM_CH)) u_req (
      .blank_i (blank_i),
      .onoff_i (onoff_i),
      .req_o   (req)
   );

   generate
      for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
         if (n == 0) begin : g_nodelay
            assign en_o[n] = req[n];
         end else begin : g_delay
            stagger_lane #(.TARGET(n * STEP_CYC), .CW(CW)) u_lane (
               .clk   (clk),
               .rst_n (rst_n),
               .req_i (req[n]),
               .en_o  (en_o[n])
            );
         end
      end
   endgenerate

   corr_pass #(.NUM_CH(NUM_CH), .CORR_W(CORR_W)) u_corr (
      .corr_i (corr_i),
      .corr_o (corr_o)
   );
endmodule

// File: rtl/stagger_gate_chk.sv
module stagger_gate_chk #(
   parameter int NUM_CH = 16,
   parameter int CORR_W = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     blank_i,
   input logic [NUM_CH-1:0]        onoff_i,
   input logic [NUM_CH*CORR_W-1:0] corr_i,
   input logic [NUM_CH-1:0]        en_o,
   input logic [NUM_CH*CORR_W-1:0] corr_o
);
   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   a_r1_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
      blank_i |-> (en_o == '0));

   a_r2_bit_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_o & ~onoff_i) == '0));

   a_r3_ch0_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (!blank_i && onoff_i[0]) |-> en_o[0]);

   a_r8_corr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      corr_o == corr_i);

   generate
      for (genvar n = 1; n < NUM_CH; n++) begin : g_lane
         // R4: a delayed channel cannot come on in the cycle its request appears
         a_r4_no_instant: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $rose(en_o[n])) |-> $past(!blank_i && onoff_i[n]));
         // R4: once on, it stays on while requested
         a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (live_q && $past(en_o[n]) && !blank_i && onoff_i[n]) |-> en_o[n]);
      end
   endgenerate
endmodule

bind stagger_gate stagger_gate_chk #(.NUM_CH(NUM_CH), .CORR_W(CORR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .blank_i (blank_i),
   .onoff_i (onoff_i),
   .corr_i  (corr_i),
   .en_o    (en_o),
   .corr_o  (corr_o)
);

// File: tb/sim_stagger_gate.sv
`timescale 1ns/1ps
module sim_stagger_gate;
   localparam int NC = 16;
   localparam int ST = 2;
   localparam int CWD = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blank_i = 1'b1;
   logic [NC-1:0] onoff_i = '0;
   logic [NC*CWD-1:0] corr_i = '0;
   logic [NC-1:0] en_o;
   logic [NC*CWD-1:0] corr_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   stagger_gate #(.NUM_CH(NC), .STEP_CYC(ST), .CORR_W(CWD)) u0 (
      .clk(clk), .rst_n(rst_n), .blank_i(blank_i), .onoff_i(onoff_i),
      .corr_i(corr_i), .en_o(en_o), .corr_o(corr_o)
   );

   task automatic chk(input string req, input logic [NC-1:0] act, input logic [NC-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // enables expected k edges after requests appear (all requests fresh)
   function automatic logic [NC-1:0] stag(input logic [NC-1:0] bits, input int k);
      logic [NC-1:0] m = '0;
      for (int n = 0; n < NC; n++) m[n] = bits[n] && (k >= n * ST);
      return m;
   endfunction

   task automatic tick();
      @(negedge clk); #1;
   endtask

   task automatic t_reset();
      chk("R1 reset", en_o, '0);
      @(negedge clk); rst_n = 1'b1; onoff_i = '1; #1;
      chk("R1 blank high", en_o, '0);
      repeat (3) tick();
      chk("R1 blank held", en_o, '0);
   endtask

   task automatic t_stagger(input logic [NC-1:0] bits, input string tag);
      @(negedge clk); blank_i = 1'b1; onoff_i = bits; #1;
      tick();
      @(negedge clk); blank_i = 1'b0; #1;
      chk({tag, " R3 k=0"}, en_o, stag(bits, 0));
      for (int k = 1; k <= (NC - 1) * ST + 2; k++) begin
         tick();
         chk({tag, " R4 stagger"}, en_o, stag(bits, k));
      end
   endtask

   task automatic t_blank_reraise();
      @(negedge clk); blank_i = 1'b1; #1;
      chk("R6 blank clears", en_o, '0);
      tick();
      @(negedge clk); blank_i = 1'b0; #1;
      chk("R6 restart k=0", en_o, stag(onoff_i, 0));
      repeat (3) tick();
      chk("R6 restart k=3", en_o, stag(onoff_i, 3));
   endtask

   task automatic t_bit_off();
      logic [NC-1:0] b;
      b = '1;
      @(negedge clk); blank_i = 1'b0; onoff_i = b; #1;
      repeat ((NC - 1) * ST) tick();
      chk("R4 all on", en_o, '1);
      @(negedge clk); b[7] = 1'b0; b[0] = 1'b0; onoff_i = b; #1;
      chk("R5 R2 immediate off", en_o, b);
      tick();
      chk("R2 stays off", en_o, b);
   endtask

   task automatic t_cancel();
      logic [NC-1:0] b;
      b = '0; b[10] = 1'b1;
      @(negedge clk); blank_i = 1'b0; onoff_i = '0; #1;
      tick();
      @(negedge clk); onoff_i = b; #1;
      repeat (7) tick();
      chk("R7 still pending", en_o, '0);
      @(negedge clk); onoff_i = '0; #1;
      chk("R7 withdrawn", en_o, '0);
      tick();
      @(negedge clk); onoff_i = b; #1;
      repeat (10 * ST - 1) tick();
      chk("R7 full wait not done", en_o, '0);
      tick();
      chk("R7 on after full wait", en_o, b);
   endtask

   task automatic t_corr();
      for (int p = 0; p < 3; p++) begin
         logic [NC*CWD-1:0] v;
         for (int n = 0; n < NC; n++) v[n*CWD +: CWD] = CWD'(n * 9 + p * 31 + 5);
         @(negedge clk); corr_i = v; #1;
         checks++;
         if (corr_o !== v) begin
            errors++;
            $display("FAIL R8 actual=%h expected=%h", corr_o, v);
         end
      end
   endtask

   initial begin
      #400000;
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_stagger('1, "all");
      t_stagger(16'hA5C3, "mix");
      t_blank_reraise();
      t_bit_off();
      t_cancel();
      t_corr();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule